// File: doc/BRIEF.md
# One-Shot Sensor Readout Controller

This block runs exactly one temperature conversion each time it is cleared. It runs on a single system clock of up to 80 MHz. A divide-by-40 or divide-by-80 counter turns that clock into a one-cycle strobe, `conv_stb_o`, which paces an external converter at 1 MHz or less. After a fixed number of strobes the controller takes one snapshot of the converter's 8-bit code from `sample_i`, presents it on `result_o` and raises `done_o`. Once `done_o` is high, the block stays idle until the next clear.

A high level on `clr_i`, or a low level on `rst_ni`, forces the outputs to the preset code at once, without waiting for a clock edge. The clear is released in step with the clock, so each new measurement starts from a divider count of zero. While `en_i` is low, all progress stops and both outputs hold their values. An unused enable is tied high and an unused clear is tied low. When the system clock is already slow enough, setting `DIV_BYPASS` removes the divider and the strobe is simply held high.

Top module: `tsense_oneshot`

## Requirements
- R1: While `clr_i` is high or `rst_ni` is low, `result_o` equals 8'hD5 and `done_o` is 0. This takes effect asynchronously, without a clock edge.
- R2: With `en_i` held high, `done_o` rises exactly 2 + DIV_RATIO*DONE_TICKS clock cycles after `clr_i` falls: two cycles of synchronizer, then DONE_TICKS divider periods. With the defaults this is 402 cycles. `done_o` only rises in the cycle after a strobe.
- R3: With the divider in use, `conv_stb_o` is a one-cycle pulse. The first pulse is visible DIV_RATIO+1 cycles after the clear is released, and later pulses follow every DIV_RATIO enabled cycles. Exactly DONE_TICKS pulses occur before `done_o` rises.
- R4: `result_o` loads `sample_i` once, on the final strobe. Changes to `sample_i` before that strobe do not affect the result.
- R5: Once `done_o` is high it stays high, `result_o` holds its value whatever `sample_i` does, and no further strobe appears until the next clear or reset.
- R6: While `en_i` is low, `conv_stb_o` is 0 and `result_o` and `done_o` do not change. Each disabled cycle delays completion by exactly one cycle.
- R7: With `DIV_BYPASS` set, `conv_stb_o` is high on every enabled cycle while a measurement is pending, and `done_o` rises 2 + DONE_TICKS cycles after the clear is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, 80 MHz or lower |
| rst_ni | input | 1 | Device reset, active low, asynchronous assertion |
| en_i | input | 1 | Active-high enable; low freezes the measurement |
| clr_i | input | 1 | Active-high asynchronous clear; its release starts a new measurement |
| sample_i | input | RES_W | Converter output code |
| result_o | output | RES_W | Captured code, or 8'hD5 after clear |
| done_o | output | 1 | High once the single measurement has completed |
| conv_stb_o | output | 1 | One-cycle converter pacing strobe |

## Verification
The assertions assume that `clr_i` and `en_i` change away from the active clock edge. They also assume that a clear or reset is held for at least one full clock cycle, which is what lets the preset check use two consecutive sampled cycles. The bench drives every input at the falling clock edge and holds each clear for two cycles. It also keeps `sample_i` changes at least a hundred cycles away from the final strobe, so the expected result never depends on a same-edge race. A second instance with the divider bypassed shares all inputs with the main instance, so both timing variants see identical stimulus.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    // Value presented on the result after clear or reset
    localparam logic [7:0] PRESET_CODE = 8'hD5;

    // Depth of the clear-release synchronizer
    localparam int SYNC_STAGES = 2;

    // Measurement phase
    typedef enum logic {
        PH_MEASURE = 1'b0,
        PH_HOLD    = 1'b1
    } phase_e;

endpackage

// File: rtl/tsense_clr_sync.sv
module tsense_clr_sync #(
    parameter int STAGES = tsense_pkg::SYNC_STAGES
) (
    input  logic clk_i,
    input  logic arst_i,
    output logic run_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/tsense_tick_div.sv
module tsense_tick_div #(
    parameter int DIV_RATIO = 40
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    output logic stb_o
);

    localparam int DIVW = $clog2(DIV_RATIO);
    localparam logic [DIVW-1:0] LAST = DIVW'(DIV_RATIO - 1);

    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } div_t;

    div_t st_d, st_q;
    logic wrap;

    assign wrap = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (go_i) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o = go_i && wrap;

endmodule

// File: rtl/tsense_seq.sv
module tsense_seq #(
    parameter int              RES_W      = 8,
    parameter int              DONE_TICKS = 10,
    parameter logic [RES_W-1:0] PRESET    = tsense_pkg::PRESET_CODE
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stb_i,
    input  logic [RES_W-1:0] sample_i,
    output logic [RES_W-1:0] result_o,
    output logic             done_o
);

    import tsense_pkg::*;

    localparam int TW = $clog2(DONE_TICKS + 1);
    localparam logic [TW-1:0] FINAL_TICK = TW'(DONE_TICKS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [TW-1:0]    ticks;
        logic [RES_W-1:0] result;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb_i && st_q.phase == PH_MEASURE) begin
            if (st_q.ticks == FINAL_TICK) begin
                st_d.phase  = PH_HOLD;
                st_d.result = sample_i;
            end else begin
                st_d.ticks = st_q.ticks + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase  <= PH_MEASURE;
            st_q.ticks  <= '0;
            st_q.result <= PRESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign done_o   = (st_q.phase == PH_HOLD);

endmodule

// File: rtl/tsense_oneshot.sv
module tsense_oneshot #(
    parameter int               DIV_RATIO  = 40,
    parameter bit               DIV_BYPASS = 1'b0,
    parameter int               DONE_TICKS = 10,
    parameter int               RES_W      = 8,
    parameter logic [RES_W-1:0] PRESET     = tsense_pkg::PRESET_CODE
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [RES_W-1:0] sample_i,
    output logic [RES_W-1:0] result_o,
    output logic             done_o,
    output logic             conv_stb_o
);

    logic arst;
    logic run_w;
    logic go;
    logic stb;

    // Either reset source clears at once; release is synchronized
    assign arst = clr_i | ~rst_ni;

    tsense_clr_sync #(
        .STAGES (tsense_pkg::SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .arst_i (arst),
        .run_o  (run_w)
    );

    // Converter only runs while enabled, released and not yet finished
    assign go = en_i & run_w & ~done_o;

    generate
        if (DIV_BYPASS) begin : g_nodiv
            assign stb = go;
        end else begin : g_div
            tsense_tick_div #(
                .DIV_RATIO (DIV_RATIO)
            ) u_div (
                .clk_i  (clk_i),
                .rst_ni (run_w),
                .go_i   (go),
                .stb_o  (stb)
            );
        end
    endgenerate

    tsense_seq #(
        .RES_W      (RES_W),
        .DONE_TICKS (DONE_TICKS),
        .PRESET     (PRESET)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (run_w),
        .stb_i    (stb),
        .sample_i (sample_i),
        .result_o (result_o),
        .done_o   (done_o)
    );

    assign conv_stb_o = stb;

endmodule

// File: rtl/tsense_oneshot_chk.sv
module tsense_oneshot_chk #(
    parameter int               RES_W      = 8,
    parameter bit               DIV_BYPASS = 1'b0,
    parameter logic [RES_W-1:0] PRESET     = 8'hD5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             clr_i,
    input logic [RES_W-1:0] sample_i,
    input logic [RES_W-1:0] result_o,
    input logic             done_o,
    input logic             conv_stb_o,
    input logic             run_i
);

    logic held_clr;
    assign held_clr = clr_i | ~rst_ni;

    // R1
    preset_on_clear_chk: assert property (@(posedge clk_i)
        (held_clr && $past(held_clr)) |-> (result_o == PRESET && !done_o));

    // R2
    done_after_stb_chk: assert property (@(posedge clk_i) disable iff (held_clr || !run_i)
        $rose(done_o) |-> $past(conv_stb_o));

    // R4
    capture_sample_chk: assert property (@(posedge clk_i) disable iff (held_clr || !run_i)
        $rose(done_o) |-> (result_o == $past(sample_i)));

    // R5
    done_sticky_chk: assert property (@(posedge clk_i) disable iff (held_clr || !run_i)
        done_o |=> (done_o && $stable(result_o)));

    // R5
    no_stb_after_done_chk: assert property (@(posedge clk_i) disable iff (held_clr || !run_i)
        done_o |-> !conv_stb_o);

    // R6
    stb_needs_en_chk: assert property (@(posedge clk_i) disable iff (held_clr || !run_i)
        conv_stb_o |-> en_i);

    // R6
    freeze_chk: assert property (@(posedge clk_i) disable iff (held_clr || !run_i)
        !en_i |=> ($stable(result_o) && $stable(done_o)));

    generate
        if (DIV_BYPASS) begin : g_byp_chk
            // R7
            stb_held_chk: assert property (@(posedge clk_i) disable iff (held_clr || !run_i)
                (en_i && !done_o) |-> conv_stb_o);
        end else begin : g_div_chk
            // R3
            stb_single_chk: assert property (@(posedge clk_i) disable iff (held_clr || !run_i)
                conv_stb_o |=> !conv_stb_o);
        end
    endgenerate

endmodule

bind tsense_oneshot tsense_oneshot_chk #(
    .RES_W      (RES_W),
    .DIV_BYPASS (DIV_BYPASS),
    .PRESET     (PRESET)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .clr_i      (clr_i),
    .sample_i   (sample_i),
    .result_o   (result_o),
    .done_o     (done_o),
    .conv_stb_o (conv_stb_o),
    .run_i      (run_w)
);

// File: tb/tsense_oneshot_test.sv
module tsense_oneshot_test;

    localparam int         DIV   = 40;
    localparam int         TICKS = 10;
    localparam logic [7:0] PRE   = 8'hD5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       clr   = 1'b0;
    logic       en    = 1'b0;
    logic [7:0] smp   = 8'h00;
    logic [7:0] res, res_b;
    logic       done, done_b, stb, stb_b;

    tsense_oneshot #(.DIV_RATIO(DIV), .DIV_BYPASS(1'b0), .DONE_TICKS(TICKS)) uut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr), .sample_i(smp),
        .result_o(res), .done_o(done), .conv_stb_o(stb));

    tsense_oneshot #(.DIV_RATIO(DIV), .DIV_BYPASS(1'b1), .DONE_TICKS(TICKS)) uut_byp (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr), .sample_i(smp),
        .result_o(res_b), .done_o(done_b), .conv_stb_o(stb_b));

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        int         lat;
        logic [7:0] val;
    } exp_t;

    exp_t q_main[$];
    exp_t q_byp[$];
    exp_t e_m, e_b;

    int cyc       = 0;
    int stb_cnt   = 0;
    int first_stb = -1;
    bit armed     = 1'b0;
    bit done_prev = 1'b0;
    bit doneb_prev = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: samples mid-cycle, pops expected items on each done rise
    always begin
        @(posedge clk);
        #2;
        if (armed) begin
            cyc++;
            if (stb) begin
                stb_cnt++;
                if (first_stb < 0) first_stb = cyc;
            end
            if (done && !done_prev) begin
                if (q_main.size() == 0) begin
                    check(1'b0, "R5", "unexpected done on main", 1, 0);
                end else begin
                    e_m = q_main.pop_front();
                    check(cyc == e_m.lat, "R2", "main done latency", cyc, e_m.lat);
                    check(res == e_m.val, "R4", "main captured code", res, e_m.val);
                    check(stb_cnt == TICKS, "R3", "strobes before done", stb_cnt, TICKS);
                    check(first_stb == DIV + 1, "R3", "first strobe cycle", first_stb, DIV + 1);
                end
            end
            if (done_b && !doneb_prev) begin
                if (q_byp.size() == 0) begin
                    check(1'b0, "R5", "unexpected done on bypass", 1, 0);
                end else begin
                    e_b = q_byp.pop_front();
                    check(cyc == e_b.lat, "R7", "bypass done latency", cyc, e_b.lat);
                    check(res_b == e_b.val, "R7", "bypass captured code", res_b, e_b.val);
                end
            end
        end
        done_prev  = done;
        doneb_prev = done_b;
    end

    // Driver: one measurement, optional pause and late sample change
    task automatic run_one(input logic [7:0] val, input logic [7:0] late_val,
                           input int pause_len, input bit via_rst);
        logic [7:0] r0;
        logic       d0;
        int         waited;
        @(negedge clk);
        if (via_rst) rst_n = 1'b0; else clr = 1'b1;
        #1;
        check(res == PRE && !done, "R1", "main preset on clear", res, PRE);
        check(res_b == PRE && !done_b, "R1", "bypass preset on clear", res_b, PRE);
        repeat (2) @(negedge clk);
        en  = 1'b1;
        smp = val;
        q_main.push_back('{2 + DIV * TICKS + pause_len, late_val});
        q_byp.push_back('{2 + TICKS, val});
        @(negedge clk);
        rst_n     = 1'b1;
        clr       = 1'b0;
        cyc       = 0;
        stb_cnt   = 0;
        first_stb = -1;
        armed     = 1'b1;
        repeat (100) @(negedge clk);
        if (pause_len > 0) begin
            en = 1'b0;
            r0 = res;
            d0 = done;
            for (int i = 0; i < pause_len; i++) begin
                @(negedge clk);
                check(!stb, "R6", "strobe while disabled", stb, 0);
            end
            check(res == r0 && done == d0, "R6", "outputs frozen while disabled", res, r0);
            en = 1'b1;
        end
        repeat (100) @(negedge clk);
        smp    = late_val;
        waited = 0;
        while ((q_main.size() != 0 || q_byp.size() != 0) && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check(waited < 2000, "R2", "done reached", waited, 0);
        repeat (50) @(negedge clk);
        smp = ~smp;
        repeat (50) @(negedge clk);
        check(res == late_val && done, "R5", "main result held after done", res, late_val);
        check(stb_cnt == TICKS, "R5", "no strobes after done", stb_cnt, TICKS);
        check(res_b == val && done_b && !stb_b, "R5", "bypass held after done", res_b, val);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(res == PRE && !done && !stb, "R1", "reset state main", res, PRE);
        check(res_b == PRE && !done_b, "R1", "reset state bypass", res_b, PRE);

        // Release with enable low: nothing may progress
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        check(!stb && !stb_b, "R6", "no strobe with enable low", stb, 0);
        check(!done && !done_b && res == PRE, "R6", "no progress with enable low", done, 0);

        run_one(8'h3C, 8'h3C, 0, 1'b0);
        run_one(8'hA7, 8'h5E, 30, 1'b0);

        // Abort a measurement by clear; bypass instance has a result by then
        @(negedge clk);
        clr = 1'b1;
        repeat (2) @(negedge clk);
        armed = 1'b0;
        smp   = 8'h91;
        clr   = 1'b0;
        repeat (150) @(negedge clk);
        check(done_b && res_b == 8'h91, "R7", "bypass finished before abort", res_b, 8'h91);
        clr = 1'b1;
        #1;
        check(res_b == PRE && !done_b, "R1", "async clear mid run", res_b, PRE);
        check(res == PRE && !done, "R1", "main preset mid run", res, PRE);
        repeat (2) @(negedge clk);
        clr = 1'b0;

        run_one(8'hFF, 8'h00, 7, 1'b1);
        run_one(8'h01, 8'h80, 0, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule